// File: doc/BRIEF.md
# Over-Temperature Alarm Register Block

This block watches two unsigned 8-bit temperature readings, one per sensing channel, and raises a shared active-low alarm when a reading rises above the limit programmed for its channel. Each weight of the byte is a whole degree: the top bit is worth 128 °C and the bottom bit 1 °C. A fresh pair of readings arrives together with a one-cycle valid strobe. The block compares each reading against its limit on that strobe and records any fault in a sticky status byte. A mask byte decides which channels may pull the alarm low.

Software reaches the block through a byte-wide address/data port with separate read and write strobes. Read data is registered, so it appears on the cycle after the read strobe. Reading the status byte returns its contents and clears it, and the alarm falls back to inactive with it. A fault that is still present on the next measurement sets the status and the alarm again. If a new fault and a status read land on the same clock edge, the new fault is kept, so no event is lost.

Top module: `ot_alarm_regs`

## Requirements
- R1: After reset the channel 1 limit (address 03h) reads 6Eh, the channel 2 limit (04h) reads 50h, the two temperature bytes (00h, 01h), the status byte (05h) and the mask byte (06h) read 00h, and `alarm_n` is high.
- R2: On each cycle with `meas_valid` high, channel 1's reading (`meas_temp[7:0]`) is stored at address 00h and channel 2's reading (`meas_temp[15:8]`) at 01h. A read strobe places the addressed byte on `host_rdata` one clock edge later.
- R3: A channel faults only when its reading is strictly greater than its limit; an equal reading is not a fault. A channel 1 fault sets status bit 7 and a channel 2 fault sets status bit 6, on the same clock edge that samples the strobe.
- R4: Status bits are sticky. Later measurements without a fault do not clear them, and writes to address 05h have no effect on them.
- R5: A read of address 05h returns the status byte as it stood before the read, clears it on that edge, and releases `alarm_n` to high on that edge when no new unmasked fault arrives.
- R6: `alarm_n` is low exactly when some status bit is set whose mask bit is 0. Mask bit 7 blocks channel 1 and bit 6 blocks channel 2. Masked faults still set their status bits, and a mask change affects `alarm_n` on the edge that writes it.
- R7: When a status read and a faulting measurement fall on the same edge, the read returns the old status, and afterwards the status holds the new fault bits and `alarm_n` follows R6.
- R8: Writes to addresses 03h and 04h set the channel 1 and channel 2 limits, which read back unchanged. The limit in force before the write edge is used for a measurement on that same edge.
- R9: Bits 5 to 0 of the status and mask bytes always read 0, even after writing 1s to them. Addresses 02h and 07h to FFh read 00h. Writes to the temperature bytes are ignored.
- R10: `host_rdata` holds its last value on every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe marking a new pair of readings |
| meas_temp | input | 16 | Readings: channel 1 in bits 7:0, channel 2 in bits 15:8 |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data, valid the cycle after `host_rd` |
| alarm_n | output | 1 | Over-temperature alarm, active low |

## Verification
The bench drives readings equal to each limit and one above it. A design that compares with greater-or-equal would raise a fault on the equal reading. It issues a status read on the same edge as a faulting measurement. A design that lets the clear win would lose that event, and the alarm would stay high. Masked channels are driven into fault to show that the status still records the fault while the alarm stays released; a design that masks the status itself, or ignores the mask, reads back the wrong byte or the wrong alarm level. Writes to the status byte, the temperature bytes and the unused mask bits are each followed by a readback. A design that decodes these addresses or bits loosely shows the change there.

// File: rtl/ot_alarm_pkg.sv
package ot_alarm_pkg;

   // Register addresses: temperatures and limits are indexed by channel.
   localparam int ADR_TEMP_BASE  = 'h00;
   localparam int ADR_LIMIT_BASE = 'h03;
   localparam int ADR_STATUS     = 'h05;
   localparam int ADR_MASK       = 'h06;

   // Highest channel count the fixed address map can hold.
   localparam int MAX_CH = ADR_STATUS - ADR_LIMIT_BASE;

   // Channel c owns flag bit (data_w - 1 - c): channel 1 at the top bit.
   function automatic int flag_pos(input int c, input int data_w);
      return data_w - 1 - c;
   endfunction

endpackage

// File: rtl/ot_alarm_chan.sv
module ot_alarm_chan #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] LIMIT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_valid,
   input  logic [DATA_W-1:0] meas_temp,
   input  logic              lim_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] temp_q,
   output logic [DATA_W-1:0] limit_q,
   output logic              fault_hit
);

   // The fault uses the limit held before any write on this same edge.
   assign fault_hit = meas_valid && (meas_temp > limit_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_q  <= '0;
         limit_q <= LIMIT_RST;
      end else begin
         if (meas_valid) temp_q  <= meas_temp;
         if (lim_we)     limit_q <= wdata;
      end
   end

   // R2: the stored reading follows the strobe
   a_r2_temp_capture: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> temp_q == $past(meas_temp));

   // R8: a limit write lands unchanged
   a_r8_limit_write: assert property (@(posedge clk) disable iff (!rst_n)
      lim_we |=> limit_q == $past(wdata));

endmodule

// File: rtl/ot_alarm_flags.sv
module ot_alarm_flags #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] fault_hit,
   input  logic              rd_clr,
   input  logic              mask_we,
   input  logic [NUM_CH-1:0] mask_wbits,
   output logic [NUM_CH-1:0] status_q,
   output logic [NUM_CH-1:0] mask_q,
   output logic              alarm_q
);

   logic [NUM_CH-1:0] status_nx;
   logic [NUM_CH-1:0] mask_nx;

   always_comb begin
      // The clear happens first and new faults are ORed in after it.
      status_nx = (rd_clr ? '0 : status_q) | fault_hit;
      mask_nx   = mask_we ? mask_wbits : mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
         alarm_q  <= 1'b0;
      end else begin
         status_q <= status_nx;
         mask_q   <= mask_nx;
         alarm_q  <= |(status_nx & ~mask_nx);
      end
   end

   // R4: without a clearing read no status bit drops
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> (status_q & $past(status_q)) == $past(status_q));

   // R5: a clearing read with no new fault empties the status
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !(|fault_hit)) |=> status_q == '0);

   // R7: a new fault survives a clear on the same edge
   a_r7_new_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_hit) |=> (status_q & $past(fault_hit)) == $past(fault_hit));

   // R6: alarm matches unmasked status
   a_r6_alarm_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_q == |(status_q & ~mask_q));

endmodule

// File: rtl/ot_alarm_rdmux.sv
module ot_alarm_rdmux
   import ot_alarm_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NUM_CH*DATA_W-1:0] temps,
   input  logic [NUM_CH*DATA_W-1:0] limits,
   input  logic [DATA_W-1:0]        status_byte,
   input  logic [DATA_W-1:0]        mask_byte,
   output logic [DATA_W-1:0]        rdata
);

   logic [DATA_W-1:0] rd_nx;

   always_comb begin
      rd_nx = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADDR_W'(ADR_TEMP_BASE + c))  rd_nx = temps[c*DATA_W +: DATA_W];
         if (addr == ADDR_W'(ADR_LIMIT_BASE + c)) rd_nx = limits[c*DATA_W +: DATA_W];
      end
      if (addr == ADDR_W'(ADR_STATUS)) rd_nx = status_byte;
      if (addr == ADDR_W'(ADR_MASK))   rd_nx = mask_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_nx;
   end

   // R10: read data holds between reads
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));

endmodule

// File: rtl/ot_alarm_regs.sv
module ot_alarm_regs
   import ot_alarm_pkg::*;
#(
   parameter int                       NUM_CH    = 2,
   parameter int                       DATA_W    = 8,
   parameter int                       ADDR_W    = 8,
   parameter logic [NUM_CH*DATA_W-1:0] LIMIT_RST = {8'h50, 8'h6E}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     meas_valid,
   input  logic [NUM_CH*DATA_W-1:0] meas_temp,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic [DATA_W-1:0]        host_wdata,
   input  logic                     host_wr,
   input  logic                     host_rd,
   output logic [DATA_W-1:0]        host_rdata,
   output logic                     alarm_n
);

   localparam int TOP_ADR = ADR_MASK;

   // Elaboration-time parameter checks.
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and the map's channel capacity");
   end
   if (NUM_CH > DATA_W) begin : g_bad_width
      $error("each channel needs its own flag bit in a data byte");
   end
   if ((1 << ADDR_W) <= TOP_ADR) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_CH*DATA_W-1:0] temps;
   logic [NUM_CH*DATA_W-1:0] limits;
   logic [NUM_CH-1:0]        fault_hit;
   logic [NUM_CH-1:0]        lim_we;
   logic [NUM_CH-1:0]        mask_wbits;
   logic [NUM_CH-1:0]        status_q;
   logic [NUM_CH-1:0]        mask_q;
   logic                     alarm_q;
   logic [DATA_W-1:0]        status_byte;
   logic [DATA_W-1:0]        mask_byte;
   logic                     rd_clr;
   logic                     mask_we;

   assign rd_clr  = host_rd && (host_addr == ADDR_W'(ADR_STATUS));
   assign mask_we = host_wr && (host_addr == ADDR_W'(ADR_MASK));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lim_we[c]     = host_wr && (host_addr == ADDR_W'(ADR_LIMIT_BASE + c));
      assign mask_wbits[c] = host_wdata[flag_pos(c, DATA_W)];

      ot_alarm_chan #(
         .DATA_W    (DATA_W),
         .LIMIT_RST (LIMIT_RST[c*DATA_W +: DATA_W])
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .meas_valid (meas_valid),
         .meas_temp  (meas_temp[c*DATA_W +: DATA_W]),
         .lim_we     (lim_we[c]),
         .wdata      (host_wdata),
         .temp_q     (temps[c*DATA_W +: DATA_W]),
         .limit_q    (limits[c*DATA_W +: DATA_W]),
         .fault_hit  (fault_hit[c])
      );
   end

   ot_alarm_flags #(
      .NUM_CH (NUM_CH)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_hit  (fault_hit),
      .rd_clr     (rd_clr),
      .mask_we    (mask_we),
      .mask_wbits (mask_wbits),
      .status_q   (status_q),
      .mask_q     (mask_q),
      .alarm_q    (alarm_q)
   );

   // Place the compact per-channel flags at their byte positions.
   always_comb begin
      status_byte = '0;
      mask_byte   = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         status_byte[flag_pos(c, DATA_W)] = status_q[c];
         mask_byte[flag_pos(c, DATA_W)]   = mask_q[c];
      end
   end

   ot_alarm_rdmux #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_rdmux (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd          (host_rd),
      .addr        (host_addr),
      .temps       (temps),
      .limits      (limits),
      .status_byte (status_byte),
      .mask_byte   (mask_byte),
      .rdata       (host_rdata)
   );

   assign alarm_n = ~alarm_q;

   // R5: after a clearing read with no faulting strobe the alarm is released
   a_r5_alarm_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !meas_valid) |=> alarm_n);

endmodule

// File: tb/tb_ot_alarm_regs.sv
`timescale 1ns/1ps
module tb_ot_alarm_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        meas_valid = 1'b0;
   logic [15:0] meas_temp = '0;
   logic [7:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic        alarm_n;

   always #4 clk = ~clk;   // 125 MHz

   ot_alarm_regs dut (
      .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_temp(meas_temp),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
      .host_rd(host_rd), .host_rdata(host_rdata), .alarm_n(alarm_n));

   int tests = 0;
   int fails = 0;

   typedef struct { logic [7:0] v; string tag; } exp_t;
   exp_t q[$];
   logic [7:0] last_exp = '0;

   // Reference model, written from the requirements.
   logic [7:0] m_t1 = 0, m_t2 = 0, m_lim1 = 8'h6E, m_lim2 = 8'h50;
   logic [7:0] m_stat = 0, m_mask = 0;

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      case (a)
         8'h00: return m_t1;
         8'h01: return m_t2;
         8'h03: return m_lim1;
         8'h04: return m_lim2;
         8'h05: return m_stat;
         8'h06: return m_mask;
         default: return 8'h00;
      endcase
   endfunction

   // Driver: one clock of stimulus, expected read data into the queue.
   task automatic op(input bit rd, input logic [7:0] ra,
                     input bit wr, input logic [7:0] wa, input logic [7:0] wd,
                     input bit mv, input logic [7:0] t1, input logic [7:0] t2,
                     input string tag);
      logic [7:0] flt;
      exp_t e;
      flt = 0;
      if (mv && t1 > m_lim1) flt[7] = 1'b1;
      if (mv && t2 > m_lim2) flt[6] = 1'b1;
      if (rd) begin
         e.v = exp_rd(ra); e.tag = tag;
         q.push_back(e);
         if (ra == 8'h05) m_stat = 0;
      end
      m_stat = m_stat | flt;
      if (wr) begin
         if (wa == 8'h03) m_lim1 = wd;
         if (wa == 8'h04) m_lim2 = wd;
         if (wa == 8'h06) m_mask = wd & 8'hC0;
      end
      if (mv) begin m_t1 = t1; m_t2 = t2; end
      host_rd = rd; host_addr = rd ? ra : wa; host_wr = wr; host_wdata = wd;
      meas_valid = mv; meas_temp = {t2, t1};
      @(posedge clk);
      @(negedge clk);
      host_rd = 0; host_wr = 0; meas_valid = 0;
   endtask

   task automatic rd_op(input logic [7:0] a, input string tag);
      op(1, a, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic wr_op(input logic [7:0] a, input logic [7:0] d, input string tag);
      op(0, 0, 1, a, d, 0, 0, 0, tag);
   endtask
   task automatic meas(input logic [7:0] t1, input logic [7:0] t2, input string tag);
      op(0, 0, 0, 0, 0, 1, t1, t2, tag);
   endtask

   task automatic check_alarm(input string tag);
      logic expv;
      expv = !(|(m_stat & ~m_mask));
      tests++;
      if (alarm_n !== expv) begin
         fails++;
         $display("FAIL %s alarm_n: got %b expected %b", tag, alarm_n, expv);
      end
   endtask

   // Monitor: a read strobe sampled at a rising edge yields data by the next falling edge.
   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= host_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         exp_t e;
         tests++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL unexpected read data %h", host_rdata);
         end else begin
            e = q.pop_front();
            last_exp = e.v;
            if (host_rdata !== e.v) begin
               fails++;
               $display("FAIL %s rdata: got %h expected %h", e.tag, host_rdata, e.v);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_alarm("R1");
      rd_op(8'h00, "R1 temp1"); rd_op(8'h01, "R1 temp2");
      rd_op(8'h03, "R1 lim1");  rd_op(8'h04, "R1 lim2");
      rd_op(8'h05, "R1 status"); rd_op(8'h06, "R1 mask");
      // R2 capture
      meas(8'd30, 8'd20, "R2");
      rd_op(8'h00, "R2 temp1"); rd_op(8'h01, "R2 temp2");
      check_alarm("R2");
      // R3 equal is not a fault, above is
      meas(8'h6E, 8'h50, "R3 equal");
      check_alarm("R3 equal");
      meas(8'h6F, 8'h50, "R3 above");
      check_alarm("R3 above");
      // R4 sticky and status writes ignored
      meas(8'd10, 8'd10, "R4");
      wr_op(8'h05, 8'h00, "R4 write");
      check_alarm("R4");
      // R5 read clears
      rd_op(8'h05, "R5 status");
      check_alarm("R5");
      rd_op(8'h05, "R5 reread");
      // R6 mask behaviour
      meas(8'd0, 8'h51, "R6 ch2");
      check_alarm("R6 ch2");
      wr_op(8'h06, 8'hFF, "R9 mask write");
      rd_op(8'h06, "R9 mask read");
      check_alarm("R6 masked");
      rd_op(8'h05, "R6 masked status");
      meas(8'hFF, 8'hFF, "R6 both");
      check_alarm("R6 both masked");
      wr_op(8'h06, 8'h40, "R6 unmask ch1");
      check_alarm("R6 unmask ch1");
      rd_op(8'h05, "R6 status both");
      check_alarm("R6 after clear");
      meas(8'h90, 8'h90, "R6 refault");
      check_alarm("R6 refault");
      // R7 simultaneous read and fault
      op(1, 8'h05, 0, 0, 0, 1, 8'h90, 8'h00, "R7 read");
      check_alarm("R7");
      rd_op(8'h05, "R7 status");
      check_alarm("R7 cleared");
      // R8 limits
      wr_op(8'h03, 8'hFE, "R8"); wr_op(8'h04, 8'h10, "R8");
      rd_op(8'h03, "R8 lim1"); rd_op(8'h04, "R8 lim2");
      wr_op(8'h06, 8'h00, "R8 unmask");
      meas(8'hFF, 8'h10, "R8 new limits");
      check_alarm("R8");
      rd_op(8'h05, "R8 status");
      // R8 limit used before write on same edge
      op(0, 0, 1, 8'h04, 8'h00, 1, 8'h00, 8'h05, "R8 same edge");
      rd_op(8'h05, "R8 same edge status");
      // R9 unmapped addresses and read-only temps
      rd_op(8'h02, "R9 addr02"); rd_op(8'h07, "R9 addr07"); rd_op(8'hFF, "R9 addrFF");
      wr_op(8'h00, 8'h55, "R9 temp write");
      rd_op(8'h00, "R9 temp1");
      // R10 hold
      repeat (3) @(negedge clk);
      tests++;
      if (host_rdata !== last_exp) begin
         fails++;
         $display("FAIL R10 hold: got %h expected %h", host_rdata, last_exp);
      end
      repeat (2) @(negedge clk);
      tests++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: got %0d pending expected 0", q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule